// File: doc/BRIEF.md
# NEC infrared remote receiver

The block decodes NEC-format remote-control frames from an already demodulated infrared line. The line is synchronised into the clock domain, and a pulse timer measures how long each mark (carrier present) and space (carrier absent) lasts. A state machine classifies each measured pulse against timing windows that allow ±25 %. It assembles 32 data bits, least significant bit first, and reports either a complete frame or a repeat code.

A small register bank receives those reports. A complete frame is accepted only if its command byte is the bitwise inverse of the complement byte that follows it. When address filtering is switched on, the 16-bit address must also equal a programmed system code. An accepted frame is latched into a code register and raises a pending interrupt. A repeat code sets a sticky repeat flag and raises the interrupt again, but leaves the code register alone. The interrupt output is the pending bit gated by a mask bit.

All timing is given in units of one NEC base period (562.5 µs), set by the parameter `CYC_PER_UNIT` in clock cycles.

| Pulse | Units |
|---|---|
| Leader mark | 16 |
| Leader space | 8 |
| Repeat space | 4 |
| Bit mark | 1 |
| Space for a 0 bit | 1 |
| Space for a 1 bit | 3 |

A frame ends with one trailing bit mark.

State machine:

| State | Waits for | Next |
|---|---|---|
| RX_IDLE | A mark ending | Leader-length mark goes to RX_HDR_GAP; any other pulse stays in RX_IDLE |
| RX_HDR_GAP | The space after the leader | Leader space goes to RX_BIT_MARK; repeat space goes to RX_REP_TAIL; anything else goes to RX_IDLE |
| RX_BIT_MARK | A bit mark | Valid goes to RX_BIT_GAP; invalid goes to RX_IDLE |
| RX_BIT_GAP | A zero or one space | Shifts the bit in, then goes to RX_BIT_MARK, or to RX_TAIL after the 32nd bit; invalid goes to RX_IDLE |
| RX_TAIL | The trailing mark | Reports a frame, then goes to RX_IDLE |
| RX_REP_TAIL | The trailing mark | Reports a repeat, then goes to RX_IDLE |

Clearing the enable bit forces RX_IDLE.

Top module: `nec_ir_rx`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. Register addresses are: 0 control, 1 system code (bits 15:0), 2 code (read only), 3 status, 4 mask.
- R2: Control bit 0 enables the receiver. While it is 0, no frame changes the code register or the status register.
- R3: Each pulse is accepted when its length in cycles lies within 75 % to 125 % of its nominal length, inclusive. Bits arrive least significant first as address-low byte, address-high byte, command byte, then inverted command byte.
- R4: An accepted frame writes the code register as {inverted command, address high, command, address low}, which puts the command in bits 15:8 (the 7-bit key in bits 14:8). It also sets status bit 3.
- R5: `irq` is status bit 3 AND mask bit 3. Writing status with bit 3 = 1 clears the pending bit.
- R6: A frame whose command byte is not the inverse of the complement byte leaves the code register and status unchanged.
- R7: With control bit 1 set, a frame whose 16-bit address {high, low} differs from the system code is dropped without any status change. With bit 1 clear, any address is accepted.
- R8: A 16-unit mark, a 4-unit space and a trailing mark form a repeat code. It sets control bit 3 (the repeat flag) and status bit 3, and leaves the code register unchanged.
- R9: An accepted complete frame clears the repeat flag. A control write with bit 3 = 0 clears it. A control write with bit 3 = 1 never sets it.
- R10: A pulse outside its window, or a frame that stops part-way, is abandoned with no status change. The next well-formed frame then decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_in | input | 1 | Demodulated IR line (active low by default) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- a disabled receiver sits in RX_IDLE;
- frame and repeat reports never coincide;
- a frame report only follows RX_TAIL;
- every measured pulse has a nonzero length;
- the code register moves only on an accepted frame, and then to the reordered word;
- a repeat sets the flag and the pending bit.

Only the bench's scenarios can show the rest:
- the exact edges of the ±25 % windows;
- rejection of frames with a bad complement or a mismatched address;
- recovery after an abandoned frame;
- the clearing rules of the repeat flag;
- the bit order decoded from random addresses and commands.

// File: rtl/nec_rx_pkg.sv
package nec_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_HDR_GAP,
        RX_BIT_MARK,
        RX_BIT_GAP,
        RX_TAIL,
        RX_REP_TAIL
    } rx_state_e;

    // Nominal pulse lengths in base units
    localparam int U_LEAD_MARK = 16;
    localparam int U_LEAD_GAP  = 8;
    localparam int U_REP_GAP   = 4;
    localparam int U_BIT_MARK  = 1;
    localparam int U_ZERO_GAP  = 1;
    localparam int U_ONE_GAP   = 3;
    localparam int U_SATURATE  = 21;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_SYS  = 3'd1;
    localparam logic [2:0] A_CODE = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_MASK = 3'd4;

    function automatic int win_lo(int units, int cpu);
        return (units * cpu * 3) / 4;
    endfunction

    function automatic int win_hi(int units, int cpu);
        return (units * cpu * 5) / 4;
    endfunction

endpackage

// File: rtl/nec_in_sync.sv
module nec_in_sync #(
    parameter int STAGES     = 2,
    parameter int ACTIVE_LOW = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_raw,
    output logic mark
);
    localparam logic IDLE_LVL = (ACTIVE_LOW != 0);

    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= {STAGES{IDLE_LVL}};
        else        sh <= {sh[STAGES-2:0], ir_raw};
    end

    generate
        if (ACTIVE_LOW != 0) begin : g_low
            assign mark = ~sh[STAGES-1];
        end else begin : g_high
            assign mark = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/nec_pulse_timer.sv
module nec_pulse_timer #(
    parameter int CNT_MAX = 420,
    parameter int W       = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mark,
    output logic         evt,
    output logic         evt_mark,
    output logic [W-1:0] dur
);
    localparam logic [W-1:0] SAT = W'(CNT_MAX);

    logic         mark_q;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= 1'b0;
            cnt    <= '0;
        end else begin
            mark_q <= mark;
            if (mark != mark_q)  cnt <= W'(1);
            else if (cnt != SAT) cnt <= cnt + W'(1);
        end
    end

    assign evt      = (mark != mark_q);
    assign evt_mark = mark_q;
    assign dur      = cnt;

    // R3
    dur_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (dur != '0));
endmodule

// File: rtl/nec_frame_fsm.sv
module nec_frame_fsm
    import nec_rx_pkg::*;
#(
    parameter int CYC_PER_UNIT = 28125,
    parameter int W            = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         evt,
    input  logic         evt_mark,
    input  logic [W-1:0] dur,
    output logic         frame_done,
    output logic         rep_done,
    output logic [31:0]  frame_word
);
    localparam logic [W-1:0] LM_LO = W'(win_lo(U_LEAD_MARK, CYC_PER_UNIT));
    localparam logic [W-1:0] LM_HI = W'(win_hi(U_LEAD_MARK, CYC_PER_UNIT));
    localparam logic [W-1:0] LG_LO = W'(win_lo(U_LEAD_GAP,  CYC_PER_UNIT));
    localparam logic [W-1:0] LG_HI = W'(win_hi(U_LEAD_GAP,  CYC_PER_UNIT));
    localparam logic [W-1:0] RG_LO = W'(win_lo(U_REP_GAP,   CYC_PER_UNIT));
    localparam logic [W-1:0] RG_HI = W'(win_hi(U_REP_GAP,   CYC_PER_UNIT));
    localparam logic [W-1:0] BM_LO = W'(win_lo(U_BIT_MARK,  CYC_PER_UNIT));
    localparam logic [W-1:0] BM_HI = W'(win_hi(U_BIT_MARK,  CYC_PER_UNIT));
    localparam logic [W-1:0] ZG_LO = W'(win_lo(U_ZERO_GAP,  CYC_PER_UNIT));
    localparam logic [W-1:0] ZG_HI = W'(win_hi(U_ZERO_GAP,  CYC_PER_UNIT));
    localparam logic [W-1:0] OG_LO = W'(win_lo(U_ONE_GAP,   CYC_PER_UNIT));
    localparam logic [W-1:0] OG_HI = W'(win_hi(U_ONE_GAP,   CYC_PER_UNIT));

    rx_state_e   st, nxt;
    logic [4:0]  bit_cnt;
    logic [31:0] shreg;
    logic        is_lead, is_lgap, is_rgap, is_bmark, is_zero, is_one;

    assign is_lead  = (dur >= LM_LO) && (dur <= LM_HI);
    assign is_lgap  = (dur >= LG_LO) && (dur <= LG_HI);
    assign is_rgap  = (dur >= RG_LO) && (dur <= RG_HI);
    assign is_bmark = (dur >= BM_LO) && (dur <= BM_HI);
    assign is_zero  = (dur >= ZG_LO) && (dur <= ZG_HI);
    assign is_one   = (dur >= OG_LO) && (dur <= OG_HI);

    always_comb begin
        nxt = st;
        if (!enable) begin
            nxt = RX_IDLE;
        end else if (evt) begin
            unique case (st)
                RX_IDLE:     if (evt_mark && is_lead) nxt = RX_HDR_GAP;
                RX_HDR_GAP:  if (is_lgap)      nxt = RX_BIT_MARK;
                             else if (is_rgap) nxt = RX_REP_TAIL;
                             else              nxt = RX_IDLE;
                RX_BIT_MARK: nxt = is_bmark ? RX_BIT_GAP : RX_IDLE;
                RX_BIT_GAP:  if (is_zero || is_one)
                                 nxt = (bit_cnt == 5'd31) ? RX_TAIL : RX_BIT_MARK;
                             else
                                 nxt = RX_IDLE;
                RX_TAIL:     nxt = RX_IDLE;
                RX_REP_TAIL: nxt = RX_IDLE;
                default:     nxt = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
            rep_done   <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            rep_done   <= 1'b0;
            if (enable && evt) begin
                unique case (st)
                    RX_HDR_GAP:  bit_cnt <= '0;
                    RX_BIT_GAP:  if (is_zero || is_one) begin
                                     shreg   <= {is_one, shreg[31:1]};
                                     bit_cnt <= bit_cnt + 5'd1;
                                 end
                    RX_TAIL:     frame_done <= is_bmark;
                    RX_REP_TAIL: rep_done   <= is_bmark;
                    default:     ;
                endcase
            end
        end
    end

    assign frame_word = shreg;

    // R2
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st == RX_IDLE));
    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && rep_done));
    // R3
    tail_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ($past(st) == RX_TAIL));
endmodule

// File: rtl/nec_ir_rx.sv
module nec_ir_rx
    import nec_rx_pkg::*;
#(
    parameter int CYC_PER_UNIT = 28125,
    parameter int SYNC_STAGES  = 2,
    parameter int ACTIVE_LOW   = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_in,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CNT_MAX = U_SATURATE * CYC_PER_UNIT;
    localparam int W       = $clog2(CNT_MAX + 1);

    logic         mark, evt, evt_mark, frame_done, rep_done;
    logic [W-1:0] dur;
    logic [31:0]  frame_word, new_code, code_q;
    logic         en_q, chk_q, rep_q, pend_q, mask_q;
    logic [15:0]  sys_q;
    logic         cmd_ok, sys_ok, frame_acc;

    nec_in_sync #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(ACTIVE_LOW)) u_sync (
        .clk(clk), .rst_n(rst_n), .ir_raw(ir_in), .mark(mark)
    );

    nec_pulse_timer #(.CNT_MAX(CNT_MAX), .W(W)) u_timer (
        .clk(clk), .rst_n(rst_n), .mark(mark),
        .evt(evt), .evt_mark(evt_mark), .dur(dur)
    );

    nec_frame_fsm #(.CYC_PER_UNIT(CYC_PER_UNIT), .W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(en_q),
        .evt(evt), .evt_mark(evt_mark), .dur(dur),
        .frame_done(frame_done), .rep_done(rep_done), .frame_word(frame_word)
    );

    // frame_word: [7:0] addr low, [15:8] addr high, [23:16] cmd, [31:24] ~cmd
    assign cmd_ok    = (frame_word[23:16] == ~frame_word[31:24]);
    assign sys_ok    = !chk_q || (frame_word[15:0] == sys_q);
    assign frame_acc = frame_done && cmd_ok && sys_ok;
    assign new_code  = {frame_word[31:24], frame_word[15:8],
                        frame_word[23:16], frame_word[7:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            chk_q  <= 1'b0;
            rep_q  <= 1'b0;
            sys_q  <= '0;
            code_q <= '0;
            pend_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    A_CTRL: begin
                        en_q  <= reg_wdata[0];
                        chk_q <= reg_wdata[1];
                        rep_q <= rep_q & reg_wdata[3];
                    end
                    A_SYS:  sys_q  <= reg_wdata;
                    A_STAT: if (reg_wdata[3]) pend_q <= 1'b0;
                    A_MASK: mask_q <= reg_wdata[3];
                    default: ;
                endcase
            end
            if (rep_done) begin
                rep_q  <= 1'b1;
                pend_q <= 1'b1;
            end
            if (frame_acc) begin
                rep_q  <= 1'b0;
                pend_q <= 1'b1;
                code_q <= new_code;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {28'd0, rep_q, 1'b0, chk_q, en_q};
            A_SYS:   reg_rdata = {16'd0, sys_q};
            A_CODE:  reg_rdata = code_q;
            A_STAT:  reg_rdata = {28'd0, pend_q, 3'd0};
            A_MASK:  reg_rdata = {28'd0, mask_q, 3'd0};
            default: reg_rdata = '0;
        endcase
    end

    assign irq = pend_q & mask_q;

    // R4
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_acc |=> (pend_q && code_q == $past(new_code)));
    // R6
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_acc |=> $stable(code_q));
    // R7
    sys_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && chk_q && frame_word[15:0] != sys_q) |=> $stable(code_q));
    // R8
    rep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_done && !frame_acc) |=> (rep_q && pend_q));
endmodule

// File: tb/tb_nec_ir_rx.sv
module tb_nec_ir_rx;
    localparam int U = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int pct_g  = 100;
    logic [31:0] exp_code = '0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    nec_ir_rx #(.CYC_PER_UNIT(U)) dut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] mk_word(logic [15:0] a, logic [7:0] c);
        return {~c, c, a};
    endfunction

    function automatic logic [31:0] mk_code(logic [15:0] a, logic [7:0] c);
        return {~c, a[15:8], c, a[7:0]};
    endfunction

    function automatic int sc(int units);
        return (units * U * pct_g) / 100;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold(logic is_mark, int cyc);
        ir_in = ~is_mark;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send_bits(logic [31:0] w, int nbits);
        hold(1'b1, sc(16));
        hold(1'b0, sc(8));
        for (int i = 0; i < nbits; i++) begin
            hold(1'b1, sc(1));
            hold(1'b0, w[i] ? sc(3) : sc(1));
        end
    endtask

    task automatic send_frame(logic [31:0] w);
        send_bits(w, 32);
        hold(1'b1, sc(1));
        hold(1'b0, 10 * U);
    endtask

    task automatic send_repeat();
        hold(1'b1, sc(16));
        hold(1'b0, sc(4));
        hold(1'b1, sc(1));
        hold(1'b0, 10 * U);
    endtask

    task automatic clr_stat();
        wr(3'd3, 16'h0008);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], rv);
            check("R1 reg", rv, 32'h0);
        end
        check("R1 irq", {31'd0, irq}, 32'h0);

        // R2 disabled receiver ignores frames
        wr(3'd4, 16'h0008);
        send_frame(mk_word(16'h00FF, 8'h12));
        rd(3'd2, rv); check("R2 code while off", rv, 32'h0);
        rd(3'd3, rv); check("R2 stat while off", rv, 32'h0);

        // R3 R4 R5 basic frame
        wr(3'd0, 16'h0001);
        send_frame(mk_word(16'h00FF, 8'h12));
        exp_code = mk_code(16'h00FF, 8'h12);
        rd(3'd2, rv); check("R4 code", rv, exp_code);
        rd(3'd3, rv); check("R4 stat", rv, 32'h8);
        check("R5 irq high", {31'd0, irq}, 32'h1);
        clr_stat();
        check("R5 irq cleared", {31'd0, irq}, 32'h0);
        rd(3'd3, rv); check("R5 stat cleared", rv, 32'h0);

        // R3 random frames with timing inside the window
        for (int k = 0; k < 8; k++) begin
            logic [15:0] a;
            logic [7:0]  c;
            a = 16'($urandom);
            c = 8'($urandom);
            pct_g = 80 + int'($urandom % 41);
            send_frame(mk_word(a, c));
            exp_code = mk_code(a, c);
            rd(3'd2, rv); check("R3 random code", rv, exp_code);
            rd(3'd3, rv); check("R3 random stat", rv, 32'h8);
            clr_stat();
        end
        pct_g = 100;

        // R3 window edges: 75 % and 125 % of one unit accepted
        pct_g = 75;
        send_frame(mk_word(16'h5A5A, 8'h33));
        exp_code = mk_code(16'h5A5A, 8'h33);
        rd(3'd2, rv); check("R3 lower edge", rv, exp_code);
        clr_stat();
        pct_g = 125;
        send_frame(mk_word(16'hA5A5, 8'h44));
        exp_code = mk_code(16'hA5A5, 8'h44);
        rd(3'd2, rv); check("R3 upper edge", rv, exp_code);
        clr_stat();

        // R10 out-of-window timing rejected
        pct_g = 70;
        send_frame(mk_word(16'h1111, 8'h55));
        rd(3'd3, rv); check("R10 short stat", rv, 32'h0);
        pct_g = 130;
        send_frame(mk_word(16'h2222, 8'h66));
        rd(3'd3, rv); check("R10 long stat", rv, 32'h0);
        rd(3'd2, rv); check("R10 code kept", rv, exp_code);
        pct_g = 100;

        // R10 abandoned frame, then recovery
        send_bits(mk_word(16'h3333, 8'h77), 10);
        hold(1'b0, 30 * U);
        rd(3'd3, rv); check("R10 partial stat", rv, 32'h0);
        send_frame(mk_word(16'h4444, 8'h88));
        exp_code = mk_code(16'h4444, 8'h88);
        rd(3'd2, rv); check("R10 recover code", rv, exp_code);
        clr_stat();

        // R6 bad complement
        send_frame({8'h00, 8'h21, 16'h0102});
        rd(3'd2, rv); check("R6 code kept", rv, exp_code);
        rd(3'd3, rv); check("R6 stat", rv, 32'h0);

        // R7 system code filtering
        wr(3'd1, 16'h1234);
        wr(3'd0, 16'h0003);
        send_frame(mk_word(16'h4321, 8'h09));
        rd(3'd2, rv); check("R7 mismatch code", rv, exp_code);
        rd(3'd3, rv); check("R7 mismatch stat", rv, 32'h0);
        send_frame(mk_word(16'h1234, 8'h0A));
        exp_code = mk_code(16'h1234, 8'h0A);
        rd(3'd2, rv); check("R7 match code", rv, exp_code);
        clr_stat();

        // R8 repeat code
        send_repeat();
        rd(3'd0, rv); check("R8 repeat flag", rv, 32'hB);
        rd(3'd3, rv); check("R8 repeat stat", rv, 32'h8);
        rd(3'd2, rv); check("R8 code unchanged", rv, exp_code);
        clr_stat();

        // R9 full frame clears repeat flag
        send_frame(mk_word(16'h1234, 8'h0B));
        exp_code = mk_code(16'h1234, 8'h0B);
        rd(3'd0, rv); check("R9 cleared by frame", rv, 32'h3);
        clr_stat();

        // R9 write 1 does not set, write 0 clears
        wr(3'd0, 16'h000B);
        rd(3'd0, rv); check("R9 write one no set", rv, 32'h3);
        send_repeat();
        wr(3'd0, 16'h000B);
        rd(3'd0, rv); check("R9 write one keeps", rv, 32'hB);
        wr(3'd0, 16'h0003);
        rd(3'd0, rv); check("R9 write zero clears", rv, 32'h3);
        clr_stat();

        // R5 masked interrupt
        wr(3'd4, 16'h0000);
        send_frame(mk_word(16'h1234, 8'h0C));
        rd(3'd3, rv); check("R5 masked stat", rv, 32'h8);
        check("R5 masked irq", {31'd0, irq}, 32'h0);
        wr(3'd4, 16'h0008);
        check("R5 unmask irq", {31'd0, irq}, 32'h1);

        summary();
    end
endmodule